// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits beside the write path of a byte-wide non-volatile memory. It watches decoded write events and recognises short command sequences written to two fixed command addresses. One sequence opens a protected page-load window. While the window is open, ordinary writes are forwarded to the page buffer. Two six-write sequences request a chip erase or enter an identification mode. A three-write sequence leaves that mode again. The block only issues the erase request. The erase timing belongs to a neighbour.

The block also holds the write-protection state. With protection on, a write that is not preceded by the unlock sequence is dropped. It never reaches the page buffer. In identification mode, the read path returns fixed codes at addresses 0 and 1. All other addresses, and all reads outside that mode, pass the memory array data through unchanged. An external load timer ends a page-load window with a one-cycle `pageEnd` pulse.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, `protectOn` equals the PROT_RESET parameter (default 1), `loadOpen`, `idMode`, `pgWrite` and `eraseReq` are 0, and `rdData` equals `arrayData`.
- R2: While protection is on and no window is open, a write that does not complete the unlock sequence produces no `pgWrite` and leaves `loadOpen` at 0.
- R3: Three writes in order open the page-load window, visible on `loadOpen` one cycle after the third write. The writes are 8'hAA to 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. Each later write in the window gives a one-cycle `pgWrite` one cycle after the write, with the write's address and data on `pgAddr` and `pgData`.
- R4: A `pageEnd` pulse closes the window, so `loadOpen` reads 0 on the next cycle. A later write is then dropped until the next unlock.
- R5: A window passes at most PAGE_BYTES (default 128) writes. Further writes in the same window produce no `pgWrite`.
- R6: Six writes request a chip erase, as a single-cycle `eraseReq` one cycle after the last write. The writes are AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555.
- R7: The same six-write shape with a last data byte of 8'h60 sets `idMode`. While `idMode` is 1, a read of address 0 returns 8'hDA and a read of address 1 returns 8'hC1. Every other read returns `arrayData`.
- R8: The writes AA@5555, 55@2AAA, F0@5555 clear `idMode`.
- R9: Only address bits 14:0 are compared with the command addresses; bits above 14 are ignored. Data is compared on all 8 bits.
- R10: A write that does not match the next expected cycle sends the decoder back to idle. If that write is AA@5555, it is taken as the first cycle of a new sequence.
- R11: With PROT_RESET=0, a plain write passes to the page buffer and opens a window. Once an unlock sequence has been given, `protectOn` is 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | One-cycle decoded write event |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| pageEnd | input | 1 | Load timer expired; closes the page-load window |
| rdAddr | input | ADDR_W | Read address |
| arrayData | input | 8 | Data read from the memory array |
| rdData | output | 8 | Read data after the identification override |
| pgWrite | output | 1 | Write accepted into the page buffer |
| pgAddr | output | ADDR_W | Address of the accepted write |
| pgData | output | 8 | Data of the accepted write |
| loadOpen | output | 1 | Page-load window open |
| eraseReq | output | 1 | Chip-erase request pulse |
| idMode | output | 1 | Identification mode active |
| protectOn | output | 1 | Software write protection enabled |

## Verification
Two sweeps cover every command byte.

- **Third-cycle sweep.** The data byte of the third cycle runs over all 256 values. Each run is followed by a probe write. This separates the one value that opens a window from the value that arms the six-write path and from values that only restart or abandon the sequence.
- **Sixth-cycle sweep.** The data byte of the sixth cycle runs over all 256 values. This isolates the erase request from identification entry and shows that no other byte does either. Every identification entry is read back at addresses 0, 1 and 2, then exited.

Further patterns target specific rules:

- **Upper address bits.** The unlock is repeated with all four settings of address bits 16:15, while a flipped bit 14 and a one-bit data error must fail. This separates the compared address bits from the ignored ones.
- **Restarts.** Interrupted sequences show whether a stray lead byte restarts the sequence or only resets it.
- **Window limit.** An over-long window of 130 writes pins down the byte limit.
- **Unprotected copy.** A second copy built with protection off at reset shows the difference between the protected and unprotected reset states.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  localparam int DATA_W = 8;
  localparam int CMP_W  = 15;
  localparam int ID_COUNT = 2;

  localparam logic [CMP_W-1:0]  CMD_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0]  CMD_ADDR_B = 15'h2AAA;

  localparam logic [DATA_W-1:0] CODE_LEAD    = 8'hAA;
  localparam logic [DATA_W-1:0] CODE_SECOND  = 8'h55;
  localparam logic [DATA_W-1:0] CODE_UNLOCK  = 8'hA0;
  localparam logic [DATA_W-1:0] CODE_IDEXIT  = 8'hF0;
  localparam logic [DATA_W-1:0] CODE_ARM     = 8'h80;
  localparam logic [DATA_W-1:0] CODE_ERASE   = 8'h10;
  localparam logic [DATA_W-1:0] CODE_IDENTER = 8'h60;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_C1, SEQ_C2, SEQ_C3, SEQ_C4, SEQ_C5
  } seqStateT;

  // decoded view of the current write, from datapath to control
  typedef struct packed {
    logic lead;
    logic second;
    logic unlock;
    logic idExit;
    logic arm;
    logic erase;
    logic idEnter;
  } cmdHitT;

  // strobes from control to datapath
  typedef struct packed {
    logic passWrite;
    logic idSelect;
  } strobeT;

  function automatic logic [DATA_W-1:0] idCodeOf(input int idx);
    return (idx == 0) ? 8'hDA : 8'hC1;
  endfunction

endpackage

// File: rtl/unlock_seq_dpath.sv
module unlock_seq_dpath
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [DATA_W-1:0]   arrayData,
  input  strobeT              strobe,
  output cmdHitT              hit,
  output logic [DATA_W-1:0]   rdData,
  output logic                pgWrite,
  output logic [ADDR_W-1:0]   pgAddr,
  output logic [DATA_W-1:0]   pgData
);

  logic atA, atB;
  assign atA = (wrAddr[CMP_W-1:0] == CMD_ADDR_A);
  assign atB = (wrAddr[CMP_W-1:0] == CMD_ADDR_B);

  always_comb begin
    hit.lead    = atA && (wrData == CODE_LEAD);
    hit.second  = atB && (wrData == CODE_SECOND);
    hit.unlock  = atA && (wrData == CODE_UNLOCK);
    hit.idExit  = atA && (wrData == CODE_IDEXIT);
    hit.arm     = atA && (wrData == CODE_ARM);
    hit.erase   = atA && (wrData == CODE_ERASE);
    hit.idEnter = atA && (wrData == CODE_IDENTER);
  end

  // page-buffer write port, registered
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgWrite <= 1'b0;
      pgAddr  <= '0;
      pgData  <= '0;
    end else begin
      pgWrite <= strobe.passWrite;
      if (strobe.passWrite) begin
        pgAddr <= wrAddr;
        pgData <= wrData;
      end
    end
  end

  // identification override on the read path
  logic [ID_COUNT-1:0] idHit;
  logic [DATA_W-1:0]   idVal [ID_COUNT];

  for (genvar g = 0; g < ID_COUNT; g++) begin : g_idCode
    assign idHit[g] = strobe.idSelect && (rdAddr == ADDR_W'(g));
    assign idVal[g] = idCodeOf(g);
  end

  always_comb begin
    rdData = arrayData;
    for (int i = 0; i < ID_COUNT; i++)
      if (idHit[i]) rdData = idVal[i];
  end

endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter bit PROT_RESET = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrValid,
  input  logic   pageEnd,
  input  cmdHitT hit,
  output strobeT strobe,
  output logic   loadOpen,
  output logic   eraseReq,
  output logic   idMode,
  output logic   protectOn
);

  localparam int CNT_W = $clog2(PAGE_BYTES + 1);

  seqStateT        seq, seqNext;
  logic [CNT_W-1:0] byteCnt;
  logic passNow, unlockNow, eraseNow, idInNow, idOutNow, openNow;

  always_comb begin
    seqNext   = seq;
    passNow   = 1'b0;
    unlockNow = 1'b0;
    eraseNow  = 1'b0;
    idInNow   = 1'b0;
    idOutNow  = 1'b0;
    if (wrValid) begin
      if (loadOpen) begin
        seqNext = SEQ_IDLE;
        passNow = (byteCnt < CNT_W'(PAGE_BYTES));
      end else begin
        // default: mismatch, restart on a lead write, else return to idle
        seqNext = hit.lead ? SEQ_C1 : SEQ_IDLE;
        passNow = !protectOn && !hit.lead;
        unique case (seq)
          SEQ_C1: if (hit.second) begin seqNext = SEQ_C2; passNow = 1'b0; end
          SEQ_C2: begin
            if (hit.unlock) begin
              seqNext = SEQ_IDLE; unlockNow = 1'b1; passNow = 1'b0;
            end else if (hit.idExit) begin
              seqNext = SEQ_IDLE; idOutNow = 1'b1; passNow = 1'b0;
            end else if (hit.arm) begin
              seqNext = SEQ_C3; passNow = 1'b0;
            end
          end
          SEQ_C3: if (hit.lead) begin seqNext = SEQ_C4; passNow = 1'b0; end
          SEQ_C4: if (hit.second) begin seqNext = SEQ_C5; passNow = 1'b0; end
          SEQ_C5: begin
            if (hit.erase) begin
              seqNext = SEQ_IDLE; eraseNow = 1'b1; passNow = 1'b0;
            end else if (hit.idEnter) begin
              seqNext = SEQ_IDLE; idInNow = 1'b1; passNow = 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign openNow = unlockNow || (passNow && !loadOpen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq       <= SEQ_IDLE;
      loadOpen  <= 1'b0;
      byteCnt   <= '0;
      eraseReq  <= 1'b0;
      idMode    <= 1'b0;
      protectOn <= PROT_RESET;
    end else begin
      seq      <= seqNext;
      eraseReq <= eraseNow;
      if (unlockNow) protectOn <= 1'b1;
      if (idInNow) idMode <= 1'b1;
      else if (idOutNow) idMode <= 1'b0;
      if (openNow) begin
        loadOpen <= 1'b1;
        byteCnt  <= unlockNow ? '0 : CNT_W'(1);
      end else if (pageEnd) begin
        loadOpen <= 1'b0;
        byteCnt  <= '0;
      end else if (passNow) begin
        byteCnt  <= byteCnt + CNT_W'(1);
      end
    end
  end

  assign strobe.passWrite = passNow;
  assign strobe.idSelect  = idMode;

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int PAGE_BYTES = 128,
  parameter bit PROT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              pageEnd,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        arrayData,
  output logic [7:0]        rdData,
  output logic              pgWrite,
  output logic [ADDR_W-1:0] pgAddr,
  output logic [7:0]        pgData,
  output logic              loadOpen,
  output logic              eraseReq,
  output logic              idMode,
  output logic              protectOn
);

  cmdHitT hit;
  strobeT strobe;

  unlock_seq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .arrayData(arrayData), .strobe(strobe), .hit(hit),
    .rdData(rdData), .pgWrite(pgWrite), .pgAddr(pgAddr), .pgData(pgData)
  );

  unlock_seq_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PROT_RESET(PROT_RESET)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .pageEnd(pageEnd), .hit(hit),
    .strobe(strobe), .loadOpen(loadOpen), .eraseReq(eraseReq),
    .idMode(idMode), .protectOn(protectOn)
  );

endmodule

// File: rtl/unlock_seq_checker.sv
module unlock_seq_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              pageEnd,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              pgWrite,
  input logic              loadOpen,
  input logic              eraseReq,
  input logic              idMode,
  input logic              protectOn
);

  assert_erase_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> !eraseReq);

  assert_protect_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    protectOn |=> protectOn);

  assert_pgwrite_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    pgWrite |-> $past(wrValid));

  assert_pgwrite_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pgWrite && $past(protectOn)) |-> $past(loadOpen));

  assert_window_close_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pageEnd && !wrValid) |=> !loadOpen);

  assert_id_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && rdAddr == '0) |-> (rdData == 8'hDA));

  assert_id_not_erase_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> !eraseReq);

endmodule

bind unlock_seq_decoder unlock_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .pageEnd(pageEnd),
  .rdAddr(rdAddr), .rdData(rdData), .pgWrite(pgWrite), .loadOpen(loadOpen),
  .eraseReq(eraseReq), .idMode(idMode), .protectOn(protectOn)
);

// File: tb/tb_unlock_seq_decoder.sv
module tb_unlock_seq_decoder;

  localparam int AW = 17;
  localparam int PB = 128;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic pageEnd = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0] arrayData = 8'h3C;

  logic [7:0] rdData, oRdData;
  logic pgWrite, loadOpen, eraseReq, idMode, protectOn;
  logic oPgWrite, oLoadOpen, oEraseReq, oIdMode, oProtectOn;
  logic [AW-1:0] pgAddr, oPgAddr;
  logic [7:0] pgData, oPgData;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // captured at the negedge after each write
  logic cPg, cOpen, cErase, cId, oPg;
  logic [AW-1:0] cAddr, oAddr;
  logic [7:0] cData, oData;

  always #4 clk = ~clk;

  unlock_seq_decoder #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROT_RESET(1'b1)) dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .pageEnd(pageEnd), .rdAddr(rdAddr), .arrayData(arrayData), .rdData(rdData),
    .pgWrite(pgWrite), .pgAddr(pgAddr), .pgData(pgData), .loadOpen(loadOpen),
    .eraseReq(eraseReq), .idMode(idMode), .protectOn(protectOn)
  );

  unlock_seq_decoder #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROT_RESET(1'b0)) dutOpen (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .pageEnd(pageEnd), .rdAddr(rdAddr), .arrayData(arrayData), .rdData(oRdData),
    .pgWrite(oPgWrite), .pgAddr(oPgAddr), .pgData(oPgData), .loadOpen(oLoadOpen),
    .eraseReq(oEraseReq), .idMode(oIdMode), .protectOn(oProtectOn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    cPg = pgWrite; cAddr = pgAddr; cData = pgData;
    cOpen = loadOpen; cErase = eraseReq; cId = idMode;
    oPg = oPgWrite; oAddr = oPgAddr; oData = oPgData;
    wrValid = 1'b0;
  endtask

  task automatic endPage();
    @(negedge clk); pageEnd = 1'b1;
    @(negedge clk); pageEnd = 1'b0;
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 17'h05555, 8'hAA);
    wr(hi | 17'h02AAA, 8'h55);
    wr(hi | 17'h05555, 8'hA0);
  endtask

  task automatic readChk(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    rdAddr = a; #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(protectOn == 1'b1, "R1 protectOn", protectOn, 1);
    check(oProtectOn == 1'b0, "R1 protectOn PROT_RESET=0", oProtectOn, 0);
    check(loadOpen == 1'b0 && pgWrite == 1'b0, "R1 loadOpen/pgWrite", {loadOpen, pgWrite}, 0);
    check(idMode == 1'b0 && eraseReq == 1'b0, "R1 idMode/eraseReq", {idMode, eraseReq}, 0);
    readChk(17'h0, 8'h3C, "R1 rdData");

    // R2 protected drop, R11 unprotected pass
    wr(17'h00123, 8'h5A);
    check(cPg == 1'b0 && cOpen == 1'b0, "R2 unlocked-less write dropped", {cPg, cOpen}, 0);
    check(oPg == 1'b1 && oAddr == 17'h00123 && oData == 8'h5A, "R11 plain write passes",
          {oPg, oData}, {1'b1, 8'h5A});
    check(oLoadOpen == 1'b1, "R11 window opened", oLoadOpen, 1);
    endPage();

    // R3 unlock then data
    unlock(17'h0);
    check(cOpen == 1'b1, "R3 window opens", cOpen, 1);
    check(oProtectOn == 1'b1, "R11 protection after unlock", oProtectOn, 1);
    for (int i = 0; i < 3; i++) begin
      wr(17'h01200 + 17'(i * 5), 8'(8'h40 + i));
      check(cPg == 1'b1 && cAddr == 17'h01200 + 17'(i * 5) && cData == 8'(8'h40 + i),
            "R3 page data", {cPg, cData}, {1'b1, 8'(8'h40 + i)});
    end
    endPage();
    check(loadOpen == 1'b0, "R4 window closed", loadOpen, 0);
    wr(17'h01300, 8'h11);
    check(cPg == 1'b0, "R4 write after close dropped", cPg, 0);
    check(oPg == 1'b0, "R11 write dropped once protected", oPg, 0);

    // R5 byte limit
    unlock(17'h0);
    for (int i = 0; i < PB + 2; i++) begin
      wr(17'h04000 + 17'(i), 8'(i));
      check(cPg == (i < PB), "R5 byte limit", cPg, (i < PB));
    end
    endPage();

    // R9 upper address bits ignored, bit 14 and data compared
    for (int h = 0; h < 4; h++) begin
      unlock(17'(h) << 15);
      check(cOpen == 1'b1, "R9 upper bits ignored", cOpen, 1);
      endPage();
    end
    wr(17'h01555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h00777, 8'h33);
    check(cPg == 1'b0, "R9 bit 14 compared", cPg, 0);
    wr(17'h05555, 8'hAB); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h00777, 8'h33);
    check(cPg == 1'b0, "R9 data compared on 8 bits", cPg, 0);

    // R10 restart rules
    wr(17'h05555, 8'hAA); unlock(17'h0);
    check(cOpen == 1'b1, "R10 repeated lead restarts", cOpen, 1);
    endPage();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); unlock(17'h0);
    check(cOpen == 1'b1, "R10 lead at third cycle restarts", cOpen, 1);
    endPage();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h12);
    wr(17'h05555, 8'hA0); wr(17'h00777, 8'h33);
    check(cPg == 1'b0, "R10 mismatch returns to idle", cPg, 0);

    // sweep third-cycle data (R3, R10)
    for (int d = 0; d < 256; d++) begin
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'(d));
      check(cOpen == (d == 8'hA0), "R3 third byte sweep open", cOpen, (d == 8'hA0));
      wr(17'h00777, 8'h33);
      check(cPg == (d == 8'hA0), "R10 third byte sweep probe", cPg, (d == 8'hA0));
      if (d == 8'hA0) endPage();
    end

    // sweep sixth-cycle data (R6, R7, R8)
    for (int d = 0; d < 256; d++) begin
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
      wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'(d));
      check(cErase == (d == 8'h10), "R6 erase request", cErase, (d == 8'h10));
      check(cId == (d == 8'h60), "R7 id entry", cId, (d == 8'h60));
      @(negedge clk);
      check(eraseReq == 1'b0, "R6 erase single cycle", eraseReq, 0);
      if (d == 8'h60) begin
        readChk(17'h0, 8'hDA, "R7 id code addr 0");
        readChk(17'h1, 8'hC1, "R7 id code addr 1");
        readChk(17'h2, 8'h3C, "R7 other addr array");
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
        check(cId == 1'b0, "R8 id exit", cId, 0);
        readChk(17'h0, 8'h3C, "R8 normal read after exit");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule